// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block models a small serial EEPROM that stores 16-bit words and talks to a host controller over chip select, a serial clock, a data input and a data output. The host raises chip select and clocks in a frame: a start bit, an opcode, an address and, for some commands, a data word. The model decodes the frame, reads or changes its internal word array, and reports the result on the data output. It can stand in for a real configuration memory in a system model, or serve as a synthesizable target when a serial-memory host is brought up.

All pins are sampled with one system clock. A serial clock rising edge is found by comparing the pin with its value one system cycle earlier. Each programming command needs an unlock command first. After the command, the device stays busy for a set number of system cycles. During that time the host can poll the data output to learn when the device is ready again. A parameter sets the address field to 6 or 8 bits.

Top module: `mw_eeprom`

## Requirements
- R1: A frame starts with the first serial clock rising edge that has chip select high, data-in at 1 and the device not busy. Zeros clocked in before that edge are ignored. The frame then takes a 2-bit opcode and an ADDR_BITS-wide address, both MSB first.
- R2: Opcode 10 is a read. On the rising edge that takes the last address bit, data-out goes to 0. Each later rising edge puts out the next bit of the addressed word, bit 15 first.
- R3: Opcode 01 is a write. It takes 16 data bits after the address, MSB first, and stores them at the address.
- R4: Opcode 11 is an erase. It sets the addressed word to 16'hFFFF.
- R5: With opcode 00, the two top address bits pick the command and the lower address bits are don't-care. Top bits 11 unlock programming and 00 lock it. Write, erase, fill-write and fill-erase have no effect while programming is locked. Reset leaves programming locked.
- R6: With opcode 00, top bits 01 start a fill-write. It takes 16 data bits and writes them to every word. Top bits 10 are a fill-erase, which sets every word to 16'hFFFF.
- R7: An accepted programming command keeps the device busy for PROG_CYCLES system cycles. While chip select is high and no frame is in progress, data-out is 0 when busy and 1 when ready. Start bits are ignored while busy.
- R8: Chip select low drops any partial frame and forces data-out to 1. When the device is neither reading nor reporting status, data-out is 1.
- R9: After reset every word reads 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data and ready status to the host |

## Verification
On every cycle, the assertions check these rules:
- Data-out is 1 whenever chip select is low.
- No programming starts while programming is locked, or while the device is still busy.
- The device is busy right after a programming command starts.
- The first bit of a read is 0.
- Programming is locked after reset.

Only the bench scenarios can show what ends up in the word array: writes, erases and fills at each address, commands ignored while locked, frames dropped when chip select falls, and the busy-then-ready sequence a host sees when it polls.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

    localparam int WORD_W = 16;
    localparam int CNT_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_HOLD
    } mw_state_e;

    typedef enum logic [2:0] {
        CMD_RD,
        CMD_WR,
        CMD_ER,
        CMD_UNLOCK,
        CMD_LOCK,
        CMD_FILL_ERASE,
        CMD_FILL_WRITE
    } mw_cmd_e;

    typedef struct packed {
        mw_cmd_e           kind;
        logic [WORD_W-1:0] data;
    } mw_req_t;

    function automatic mw_cmd_e decode_cmd(input logic [1:0] opc, input logic [1:0] top);
        mw_cmd_e c;
        case (opc)
            2'b10:   c = CMD_RD;
            2'b01:   c = CMD_WR;
            2'b11:   c = CMD_ER;
            default: begin
                case (top)
                    2'b11:   c = CMD_UNLOCK;
                    2'b10:   c = CMD_FILL_ERASE;
                    2'b01:   c = CMD_FILL_WRITE;
                    default: c = CMD_LOCK;
                endcase
            end
        endcase
        return c;
    endfunction

    function automatic logic cmd_needs_data(input mw_cmd_e c);
        return (c == CMD_WR) || (c == CMD_FILL_WRITE);
    endfunction

    function automatic logic cmd_programs(input mw_cmd_e c);
        return (c == CMD_WR) || (c == CMD_ER) ||
               (c == CMD_FILL_ERASE) || (c == CMD_FILL_WRITE);
    endfunction

    function automatic logic cmd_is_fill(input mw_cmd_e c);
        return (c == CMD_FILL_ERASE) || (c == CMD_FILL_WRITE);
    endfunction

endpackage

// File: rtl/mw_frame_ctrl.sv
module mw_frame_ctrl
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs,
    input  logic                 sk,
    input  logic                 di,
    input  logic                 busy,
    input  logic [WORD_W-1:0]    rd_data,
    output logic [ADDR_BITS-1:0] rd_addr,
    output logic                 req_valid,
    output mw_req_t              req,
    output logic [ADDR_BITS-1:0] req_addr,
    output logic                 rd_active,
    output logic                 sdo
);

    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] READ_END  = CNT_W'(WORD_W);

    mw_state_e             state_q;
    logic                  sk_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [1:0]            opc_q;
    logic [ADDR_BITS-1:0]  addr_q;
    logic [WORD_W-1:0]     data_q;
    logic [WORD_W-1:0]     word_q;
    logic                  bit_q;

    logic                  rise;
    logic [ADDR_BITS-1:0]  addr_n;
    logic [WORD_W-1:0]     data_n;
    mw_cmd_e               cmd_at_addr;
    mw_cmd_e               cmd_held;

    assign rise        = sk & ~sk_q;
    assign addr_n      = {addr_q[ADDR_BITS-2:0], di};
    assign data_n      = {data_q[WORD_W-2:0], di};
    assign cmd_at_addr = decode_cmd(opc_q, addr_n[ADDR_BITS-1 -: 2]);
    assign cmd_held    = decode_cmd(opc_q, addr_q[ADDR_BITS-1 -: 2]);
    assign rd_addr     = addr_n;
    assign rd_active   = (state_q == ST_READ);

    always_ff @(posedge clk) begin
        if (rst) sk_q <= 1'b0;
        else     sk_q <= sk;
    end

    always_ff @(posedge clk) begin
        req_valid <= 1'b0;
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            opc_q    <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            word_q   <= '0;
            bit_q    <= 1'b1;
            req      <= '{kind: CMD_LOCK, data: '0};
            req_addr <= '0;
        end else if (!cs) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (rise) begin
            case (state_q)
                ST_IDLE: begin
                    if (di && !busy) begin
                        state_q <= ST_OPC;
                        cnt_q   <= '0;
                    end
                end
                ST_OPC: begin
                    opc_q <= {opc_q[0], di};
                    if (cnt_q == CNT_W'(1)) begin
                        state_q <= ST_ADDR;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_ADDR: begin
                    addr_q <= addr_n;
                    if (cnt_q == ADDR_LAST) begin
                        cnt_q <= '0;
                        if (cmd_at_addr == CMD_RD) begin
                            state_q <= ST_READ;
                            word_q  <= rd_data;
                            bit_q   <= 1'b0;
                        end else if (cmd_needs_data(cmd_at_addr)) begin
                            state_q <= ST_DATA;
                        end else begin
                            state_q   <= ST_HOLD;
                            req_valid <= 1'b1;
                            req.kind  <= cmd_at_addr;
                            req.data  <= '0;
                            req_addr  <= addr_n;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    data_q <= data_n;
                    if (cnt_q == DATA_LAST) begin
                        state_q   <= ST_HOLD;
                        req_valid <= 1'b1;
                        req.kind  <= cmd_held;
                        req.data  <= data_n;
                        req_addr  <= addr_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_READ: begin
                    if (cnt_q != READ_END) begin
                        bit_q  <= word_q[WORD_W-1];
                        word_q <= {word_q[WORD_W-2:0], 1'b0};
                        cnt_q  <= cnt_q + 1'b1;
                    end else begin
                        state_q <= ST_HOLD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (!cs)                       sdo = 1'b1;
        else if (state_q == ST_READ)   sdo = bit_q;
        else if (state_q == ST_IDLE)   sdo = ~busy;
        else                           sdo = 1'b1;
    end

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  mw_req_t              req,
    input  logic [ADDR_BITS-1:0] req_addr,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 wen,
    output logic                 prog_start
);

    localparam int DEPTH = 1 << ADDR_BITS;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] fill_val;
    logic              is_fill;

    assign prog_start = req_valid && wen && cmd_programs(req.kind);
    assign is_fill    = cmd_is_fill(req.kind);
    assign fill_val   = ((req.kind == CMD_ER) || (req.kind == CMD_FILL_ERASE))
                        ? '1 : req.data;
    assign rd_data    = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst)                                       wen <= 1'b0;
        else if (req_valid && req.kind == CMD_UNLOCK)  wen <= 1'b1;
        else if (req_valid && req.kind == CMD_LOCK)    wen <= 1'b0;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [WORD_W-1:0] cell_q;
        logic              hit;

        assign hit    = prog_start && (is_fill || (req_addr == ADDR_BITS'(g)));
        assign mem[g] = cell_q;

        always_ff @(posedge clk) begin
            if (rst)      cell_q <= '1;
            else if (hit) cell_q <= fill_val;
        end
    end

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int TW = $clog2(PROG_CYCLES + 1);

    logic [TW-1:0] left_q;

    assign busy = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (start)         left_q <= TW'(PROG_CYCLES);
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_eeprom_pkg::*;
#(
    parameter int ADDR_BITS   = 6,
    parameter int PROG_CYCLES = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic sdo
);

    logic                 busy_w;
    logic                 prog_start_w;
    logic                 wen_w;
    logic                 rd_active_w;
    logic                 req_valid_w;
    mw_req_t              req_w;
    logic [ADDR_BITS-1:0] req_addr_w;
    logic [ADDR_BITS-1:0] rd_addr_w;
    logic [WORD_W-1:0]    rd_data_w;

    mw_frame_ctrl #(.ADDR_BITS(ADDR_BITS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cs        (cs),
        .sk        (sk),
        .di        (di),
        .busy      (busy_w),
        .rd_data   (rd_data_w),
        .rd_addr   (rd_addr_w),
        .req_valid (req_valid_w),
        .req       (req_w),
        .req_addr  (req_addr_w),
        .rd_active (rd_active_w),
        .sdo       (sdo)
    );

    mw_word_store #(.ADDR_BITS(ADDR_BITS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid_w),
        .req        (req_w),
        .req_addr   (req_addr_w),
        .rd_addr    (rd_addr_w),
        .rd_data    (rd_data_w),
        .wen        (wen_w),
        .prog_start (prog_start_w)
    );

    mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (prog_start_w),
        .busy  (busy_w)
    );

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic clk,
    input logic rst,
    input logic cs,
    input logic sdo,
    input logic busy,
    input logic prog_start,
    input logic wen,
    input logic rd_active
);

    assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
        !cs |-> sdo);

    assert_prog_gated_R5: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> wen);

    assert_locked_after_reset_R5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wen);

    assert_busy_follows_R7: assert property (@(posedge clk) disable iff (rst)
        prog_start |=> busy);

    assert_no_start_when_busy_R7: assert property (@(posedge clk) disable iff (rst)
        prog_start |-> !busy);

    assert_lead_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(rd_active) && cs) |-> !sdo);

endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs         (cs),
    .sdo        (sdo),
    .busy       (busy_w),
    .prog_start (prog_start_w),
    .wen        (wen_w),
    .rd_active  (rd_active_w)
);

// File: tb/mw_eeprom_test.sv
`timescale 1ns/1ps
module mw_eeprom_test;

    localparam int AW    = 6;
    localparam int PC    = 40;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs  = 1'b0;
    logic sk  = 1'b0;
    logic di  = 1'b0;
    logic sdo;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mw_eeprom #(.ADDR_BITS(AW), .PROG_CYCLES(PC)) uut (
        .clk (clk), .rst (rst), .cs (cs), .sk (sk), .di (di), .sdo (sdo)
    );

    function automatic logic [15:0] pattern(input int a);
        return 16'((a * 257) ^ 16'h5A3C);
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        di = b;
        wait_clk(2);
        sk = 1'b1;
        wait_clk(3);
        sk = 1'b0;
        wait_clk(1);
    endtask

    task automatic cs_begin();
        cs = 1'b1;
        wait_clk(2);
    endtask

    task automatic cs_end();
        sk = 1'b0;
        di = 1'b0;
        cs = 1'b0;
        wait_clk(3);
    endtask

    task automatic send_hdr(input logic [1:0] opc, input logic [AW-1:0] addr);
        pulse(1'b1);
        pulse(opc[1]);
        pulse(opc[0]);
        for (int i = AW - 1; i >= 0; i--) pulse(addr[i]);
    endtask

    task automatic read_body(output logic [15:0] v, output logic lead);
        lead = sdo;
        v = '0;
        for (int i = 0; i < 16; i++) begin
            pulse(1'b0);
            v = {v[14:0], sdo};
        end
    endtask

    task automatic read_word(input int a, output logic [15:0] v, output logic lead);
        cs_begin();
        send_hdr(2'b10, AW'(a));
        read_body(v, lead);
        cs_end();
    endtask

    task automatic expect_word(input int a, input logic [15:0] exp, input string tag);
        logic [15:0] v;
        logic lead;
        read_word(a, v, lead);
        check(lead == 1'b0, {tag, " R2 leading zero"}, {15'd0, lead}, 16'd0);
        check(v == exp, tag, v, exp);
    endtask

    task automatic prog(input logic [1:0] opc, input logic [AW-1:0] addr,
                        input logic has_data, input logic [15:0] data,
                        input logic expect_busy, input string tag);
        int n;
        cs_begin();
        send_hdr(opc, addr);
        if (has_data)
            for (int i = 15; i >= 0; i--) pulse(data[i]);
        cs_end();
        cs = 1'b1;
        wait_clk(1);
        if (expect_busy) begin
            check(sdo == 1'b0, {tag, " R7 busy after command"}, {15'd0, sdo}, 16'd0);
            pulse(1'b1);
            check(sdo == 1'b0, {tag, " R7 start bit ignored while busy"}, {15'd0, sdo}, 16'd0);
            n = 0;
            while (sdo == 1'b0 && n < 4 * PC) begin
                wait_clk(1);
                n++;
            end
            check(sdo == 1'b1 && n <= PC, {tag, " R7 ready within PROG_CYCLES"},
                  16'(n), 16'(PC));
        end else begin
            check(sdo == 1'b1, {tag, " R5 no busy when locked"}, {15'd0, sdo}, 16'd1);
        end
        cs_end();
    endtask

    task automatic unlock();
        cs_begin();
        send_hdr(2'b00, {2'b11, 4'b1010});
        cs_end();
    endtask

    task automatic lock();
        cs_begin();
        send_hdr(2'b00, {2'b00, 4'b0111});
        cs_end();
    endtask

    initial begin
        wait_clk(150_000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic lead;

        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);

        // R9 / R8: reset state
        check(sdo == 1'b1, "R8 idle output after reset", {15'd0, sdo}, 16'd1);
        expect_word(0, 16'hFFFF, "R9 erased after reset");
        expect_word(DEPTH - 1, 16'hFFFF, "R9 erased after reset top");

        // R5: locked after reset, write has no effect
        prog(2'b01, AW'(5), 1'b1, 16'h1234, 1'b0, "R5 write locked");
        expect_word(5, 16'hFFFF, "R5 locked write ignored");

        // R3 / R7: unlock, write every address
        unlock();
        for (int a = 0; a < DEPTH; a++)
            prog(2'b01, AW'(a), 1'b1, pattern(a), 1'b1, "R3 write");
        for (int a = 0; a < DEPTH; a++)
            expect_word(a, pattern(a), "R3 readback");

        // R4: erase one word, neighbours intact
        prog(2'b11, AW'(7), 1'b0, 16'h0, 1'b1, "R4 erase");
        expect_word(7, 16'hFFFF, "R4 erased word");
        expect_word(6, pattern(6), "R4 neighbour below");
        expect_word(8, pattern(8), "R4 neighbour above");

        // R1: leading zeros before the start bit
        cs_begin();
        pulse(1'b0); pulse(1'b0); pulse(1'b0);
        send_hdr(2'b10, AW'(9));
        read_body(v, lead);
        cs_end();
        check(lead == 1'b0 && v == pattern(9), "R1 leading zeros ignored", v, pattern(9));

        // R8: partial frame aborted by chip select
        cs_begin();
        pulse(1'b1); pulse(1'b0); pulse(1'b1);
        pulse(1'b0); pulse(1'b0); pulse(1'b1);
        cs_end();
        check(sdo == 1'b1, "R8 output high with cs low", {15'd0, sdo}, 16'd1);
        cs_begin();
        check(sdo == 1'b1, "R8 not busy after aborted frame", {15'd0, sdo}, 16'd1);
        cs_end();
        expect_word(10, pattern(10), "R8 aborted frame no effect");

        // R5: lock, then every programming command ignored
        lock();
        prog(2'b01, AW'(11), 1'b1, 16'h0000, 1'b0, "R5 write after lock");
        prog(2'b11, AW'(12), 1'b0, 16'h0, 1'b0, "R5 erase after lock");
        prog(2'b00, {2'b10, 4'b0000}, 1'b0, 16'h0, 1'b0, "R5 fill-erase after lock");
        prog(2'b00, {2'b01, 4'b0000}, 1'b1, 16'h0F0F, 1'b0, "R5 fill-write after lock");
        expect_word(11, pattern(11), "R5 locked write");
        expect_word(12, pattern(12), "R5 locked erase");
        expect_word(13, pattern(13), "R5 locked fill");

        // R6: fill-write then fill-erase
        unlock();
        prog(2'b00, {2'b01, 4'b1001}, 1'b1, 16'hA5C3, 1'b1, "R6 fill-write");
        for (int a = 0; a < DEPTH; a++)
            expect_word(a, 16'hA5C3, "R6 fill-write readback");
        prog(2'b00, {2'b10, 4'b0110}, 1'b0, 16'h0, 1'b1, "R6 fill-erase");
        for (int a = 0; a < DEPTH; a++)
            expect_word(a, 16'hFFFF, "R6 fill-erase readback");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule